// File: doc/BRIEF.md
# Stored-Program Counter Machine

This block is a small multicycle processor. Its program and its data share one word-addressed register array. A finite-state controller steps through that array. For each instruction it reads the opcode word, then the register-number word, and then reads the named register indirectly into a scratch register. It then either writes back an incremented or decremented value, or takes a branch decision. The instruction set has four operations: increment, decrement, jump-if-zero and halt. Those three working operations are enough to move the contents of one register into another.

A host fills the whole array through the load port while the machine sits idle after reset. The host then pulses `start`, which begins execution at address 0. When the machine halts, `done` goes high and stays high. The host then reads result words through a separate read port, which has a one-cycle latency.

Top module: `counter_machine`

## Requirements
- R1: After reset `done` is 0 and the machine is idle. While idle, a cycle with `ld_en` high writes `ld_data` to word `ld_addr`. The read port returns word `peek_addr` on `peek_data` one clock later.
- R2: A `start` pulse while idle begins execution at address 0. After each instruction, execution continues at the word that follows its last operand, unless a jump is taken.
- R3: Opcode 1 (INC h) occupies two words: the opcode word, then the register number h. It adds 1 to word h modulo 2^16, so 0xFFFF becomes 0.
- R4: Opcode 2 (DEC h) occupies two words. It subtracts 1 from word h. A word that is already 0 stays 0.
- R5: Opcode 3 (JZ h,t) occupies three words: the opcode word, h, then t. When word h is non-zero, the target word is skipped and execution continues at the word after t.
- R6: When word h of a JZ is zero, execution continues at address t, taken from its low 5 bits.
- R7: Opcode 0 halts. Any opcode value above 3 also halts. Once halted, `done` is 1 and stays 1 until reset, and memory no longer changes.
- R8: While the machine is running or halted, `ld_en` and `start` have no effect on memory or on execution.
- R9: Counted in clocks after the edge that accepts `start`:
  - INC, DEC and a JZ that is not taken each take 5 clocks.
  - A taken JZ takes 6 clocks.
  - HALT raises `done` 2 clocks after its fetch begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Host write strobe, effective only while idle |
| ld_addr | input | 5 | Host write address |
| ld_data | input | 16 | Host write data |
| start | input | 1 | Begin execution at address 0 |
| done | output | 1 | Machine has halted |
| peek_addr | input | 5 | Result read address |
| peek_data | output | 16 | Word at `peek_addr`, one clock later |

## Verification
The bench runs a register-move program whose loop uses both a jump that is not taken and a jump that is always taken. A design that read the target word on a non-zero test, or that jumped to the wrong word, would leave the wrong count in the destination or never halt. Separate programs exercise an increment at 0xFFFF, a decrement at zero, and an undefined opcode. A design without the wrap or without the floor would return wrong values, and one that decoded the bad opcode would run into data. Host writes and start pulses issued mid-run must leave a spare word at zero and the result intact. The exact clock count to `done` for each program exposes any added or missing controller state.

// File: rtl/cm_pkg.sv
package cm_pkg;
    parameter int MEM_WORDS = 32;
    parameter int WORD_W    = 16;
    localparam int ADDR_W   = $clog2(MEM_WORDS);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        OP_HALT = 2'd0,
        OP_INC  = 2'd1,
        OP_DEC  = 2'd2,
        OP_JZ   = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_DECODE,
        S_OPADDR,
        S_OPREAD,
        S_EXEC,
        S_JZTGT,
        S_HALTED
    } state_e;

    typedef struct packed {
        logic  en;
        addr_t addr;
        word_t data;
    } wr_req_t;

    // Any word outside the four defined codes is treated as a stop.
    function automatic op_e decode_op(word_t w);
        if (w > word_t'(3)) return OP_HALT;
        return op_e'(w[1:0]);
    endfunction

    function automatic logic is_write_op(op_e op);
        return (op == OP_INC) || (op == OP_DEC);
    endfunction
endpackage

// File: rtl/cm_store.sv
module cm_store
    import cm_pkg::*;
#(
    parameter int DEPTH = MEM_WORDS,
    parameter int WIDTH = WORD_W,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata,
    input  logic [AW-1:0]    paddr,
    output logic [WIDTH-1:0] pdata
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
        rdata <= cells[raddr];
        pdata <= cells[paddr];
    end
endmodule

// File: rtl/cm_step.sv
module cm_step
    import cm_pkg::*;
#(
    parameter int WIDTH = WORD_W
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] val,
    output logic [WIDTH-1:0] res
);
    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] ZERO = '0;

    always_comb begin
        unique case (op)
            OP_INC:  res = val + ONE;
            OP_DEC:  res = (val == ZERO) ? ZERO : val - ONE;
            default: res = val;
        endcase
    end
endmodule

// File: rtl/cm_seq.sv
module cm_seq
    import cm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  word_t  rdata,
    output addr_t  raddr,
    output state_e state,
    output addr_t  pc,
    output op_e    op,
    output addr_t  reg_num,
    output word_t  scratch,
    output logic   wr_en
);
    state_e state_q;
    addr_t  pc_q;
    op_e    op_q;
    addr_t  reg_q;
    word_t  scr_q;
    op_e    dec_op;

    assign dec_op = decode_op(rdata);

    // Read address: the program counter, except when the register-number
    // word just returned must be used as an indirect address.
    always_comb begin
        raddr = pc_q;
        if (state_q == S_OPADDR) raddr = rdata[ADDR_W-1:0];
    end

    assign wr_en   = (state_q == S_EXEC) && is_write_op(op_q);
    assign state   = state_q;
    assign pc      = pc_q;
    assign op      = op_q;
    assign reg_num = reg_q;
    assign scratch = scr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            pc_q    <= '0;
            op_q    <= OP_HALT;
            reg_q   <= '0;
            scr_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        pc_q    <= '0;
                        state_q <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    pc_q    <= pc_q + addr_t'(1);
                    state_q <= S_DECODE;
                end
                S_DECODE: begin
                    op_q <= dec_op;
                    if (dec_op == OP_HALT) begin
                        state_q <= S_HALTED;
                    end else begin
                        pc_q    <= pc_q + addr_t'(1);
                        state_q <= S_OPADDR;
                    end
                end
                S_OPADDR: begin
                    reg_q   <= rdata[ADDR_W-1:0];
                    state_q <= S_OPREAD;
                end
                S_OPREAD: begin
                    scr_q   <= rdata;
                    state_q <= S_EXEC;
                end
                S_EXEC: begin
                    if (op_q == OP_JZ) begin
                        if (scr_q != '0) begin
                            pc_q    <= pc_q + addr_t'(1);
                            state_q <= S_FETCH;
                        end else begin
                            state_q <= S_JZTGT;
                        end
                    end else begin
                        state_q <= S_FETCH;
                    end
                end
                S_JZTGT: begin
                    pc_q    <= rdata[ADDR_W-1:0];
                    state_q <= S_FETCH;
                end
                default: state_q <= S_HALTED;
            endcase
        end
    end
endmodule

// File: rtl/counter_machine.sv
module counter_machine
    import cm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ld_en,
    input  logic [4:0]  ld_addr,
    input  logic [15:0] ld_data,
    input  logic        start,
    output logic        done,
    input  logic [4:0]  peek_addr,
    output logic [15:0] peek_data
);
    state_e  state;
    addr_t   pc;
    op_e     op;
    addr_t   reg_num;
    word_t   scratch;
    word_t   rdata;
    addr_t   raddr;
    word_t   step_res;
    logic    seq_we;
    logic    host_we;
    wr_req_t wr;

    cm_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .rdata   (rdata),
        .raddr   (raddr),
        .state   (state),
        .pc      (pc),
        .op      (op),
        .reg_num (reg_num),
        .scratch (scratch),
        .wr_en   (seq_we)
    );

    cm_step #(.WIDTH(WORD_W)) u_step (
        .op  (op),
        .val (scratch),
        .res (step_res)
    );

    assign host_we = ld_en && (state == S_IDLE);

    always_comb begin
        wr.en   = seq_we | host_we;
        wr.addr = seq_we ? reg_num  : addr_t'(ld_addr);
        wr.data = seq_we ? step_res : word_t'(ld_data);
    end

    cm_store #(.DEPTH(MEM_WORDS), .WIDTH(WORD_W)) u_store (
        .clk   (clk),
        .we    (wr.en),
        .waddr (wr.addr),
        .wdata (wr.data),
        .raddr (raddr),
        .rdata (rdata),
        .paddr (addr_t'(peek_addr)),
        .pdata (peek_data)
    );

    assign done = (state == S_HALTED);
endmodule

// File: rtl/cm_checker.sv
module cm_checker
    import cm_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   done,
    input state_e state,
    input addr_t  pc,
    input op_e    op,
    input word_t  scratch,
    input word_t  rdata,
    input logic   mem_we,
    input word_t  wdata
);
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done |=> done);  // R7

    AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_we);  // R7

    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE) |=> (state == S_IDLE) || (pc == '0));  // R2

    AST_WRITE_IN_EXEC_ONLY: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (state == S_IDLE) || (state == S_EXEC));  // R8

    AST_JZ_SKIP: assert property (@(posedge clk) disable iff (rst)
        (state == S_EXEC && op == OP_JZ && scratch != '0)
        |=> (state == S_FETCH) && (pc == $past(pc) + addr_t'(1)));  // R5

    AST_JZ_TAKE: assert property (@(posedge clk) disable iff (rst)
        (state == S_JZTGT) |=> (pc == $past(rdata[ADDR_W-1:0])));  // R6

    AST_DEC_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (state == S_EXEC && op == OP_DEC && scratch == '0)
        |-> mem_we && (wdata == '0));  // R4
endmodule

bind counter_machine cm_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .done    (done),
    .state   (state),
    .pc      (pc),
    .op      (op),
    .scratch (scratch),
    .rdata   (rdata),
    .mem_we  (wr.en),
    .wdata   (wr.data)
);

// File: tb/tb_counter_machine.sv
module tb_counter_machine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [4:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic        start = 1'b0;
    logic        done;
    logic [4:0]  peek_addr = '0;
    logic [15:0] peek_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    localparam int WATCHDOG = 100000;

    typedef struct {
        int          addr;
        logic [15:0] val;
        string       tag;
    } exp_t;

    exp_t        expq[$];
    logic [15:0] img[32];

    counter_machine dut (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (ld_en),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .start     (start),
        .done      (done),
        .peek_addr (peek_addr),
        .peek_data (peek_data)
    );

    always #5 clk = ~clk;

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual cycles=%0d expected below %0d", cyc, WATCHDOG);
                report();
                $finish;
            end
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic clear_img();
        for (int i = 0; i < 32; i++) img[i] = '0;
    endtask

    task automatic load_img();
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = 5'(i); ld_data = img[i];
        end
        @(negedge clk) ld_en = 1'b0;
    endtask

    // Driver side: queue an expected word.
    task automatic expect_word(input int a, input logic [15:0] v, input string tag);
        exp_t e;
        e.addr = a; e.val = v; e.tag = tag;
        expq.push_back(e);
    endtask

    // Monitor side: pop each expected item, read it back and compare.
    task automatic drain();
        while (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            @(negedge clk) peek_addr = 5'(e.addr);
            @(posedge clk); #1;
            check(e.tag, peek_data, e.val);
        end
    endtask

    task automatic run(input int exp_cyc, input string tag);
        int n;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        n = 0;
        while (!done && n < 5000) begin
            @(posedge clk); #1;
            n++;
        end
        check(tag, n, exp_cyc);
    endtask

    // Program image that moves word 30 into word 31.
    task automatic move_prog(input logic [15:0] v);
        clear_img();
        img[0] = 3; img[1] = 30; img[2] = 10;
        img[3] = 2; img[4] = 30;
        img[5] = 1; img[6] = 31;
        img[7] = 3; img[8] = 29; img[9] = 0;
        img[10] = 0;
        img[30] = v;
    endtask

    initial begin
        do_reset();
        #1;
        check("R1 done low after reset", done, 0);

        // R1: load then read back with one clock of latency
        clear_img();
        img[12] = 16'hBEEF;
        load_img();
        expect_word(12, 16'hBEEF, "R1 host load and peek");
        drain();

        // R2 R5 R6 R4 R3: move three units from word 30 to word 31
        do_reset();
        move_prog(16'd3);
        load_img();
        run(3 * 21 + 6 + 2, "R9 R2 move program cycle count");
        check("R7 done after halt", done, 1);
        expect_word(30, 16'd0, "R2 R4 source emptied");
        expect_word(31, 16'd3, "R3 R6 destination filled");
        expect_word(10, 16'd0, "R7 halt word intact");
        drain();
        check("R7 done still held", done, 1);

        // R3 wrap, R4 floor and ordinary decrement
        do_reset();
        clear_img();
        img[0] = 1; img[1] = 20;
        img[2] = 2; img[3] = 21;
        img[4] = 2; img[5] = 22;
        img[6] = 0;
        img[20] = 16'hFFFF; img[21] = 16'd0; img[22] = 16'd5;
        load_img();
        run(5 + 5 + 5 + 2, "R9 inc dec cycle count");
        expect_word(20, 16'h0000, "R3 increment wraps");
        expect_word(21, 16'h0000, "R4 decrement floor");
        expect_word(22, 16'h0004, "R4 decrement");
        drain();

        // R5: non-zero test skips the target and continues after it
        do_reset();
        clear_img();
        img[0] = 3; img[1] = 20; img[2] = 7;
        img[3] = 1; img[4] = 21;
        img[5] = 0;
        img[7] = 1; img[8] = 22; img[9] = 0;
        img[20] = 16'd9;
        load_img();
        run(5 + 5 + 2, "R9 R5 untaken jump cycle count");
        expect_word(21, 16'd1, "R5 fall-through path executed");
        expect_word(22, 16'd0, "R5 target path not executed");
        drain();

        // R7: undefined opcode halts
        do_reset();
        clear_img();
        img[0] = 16'd7; img[1] = 1; img[2] = 20;
        load_img();
        run(2, "R7 undefined opcode halts");
        repeat (4) @(negedge clk);
        check("R7 done held", done, 1);
        expect_word(20, 16'd0, "R7 nothing executed past bad opcode");
        drain();

        // R8: host writes and start pulses during a run are ignored
        do_reset();
        move_prog(16'd40);
        load_img();
        fork
            run(40 * 21 + 6 + 2, "R8 run length unchanged");
            begin
                repeat (30) @(negedge clk);
                ld_en = 1'b1; ld_addr = 5'd28; ld_data = 16'h1234; start = 1'b1;
                @(negedge clk);
                ld_en = 1'b0; start = 1'b0;
            end
        join
        @(negedge clk) ld_en = 1'b1; ld_addr = 5'd27; ld_data = 16'h5555;
        @(negedge clk) ld_en = 1'b0;
        expect_word(28, 16'd0, "R8 write during run ignored");
        expect_word(27, 16'd0, "R8 write after halt ignored");
        expect_word(31, 16'd40, "R8 result intact");
        drain();

        report();
        $finish;
    end
endmodule